// File: doc/BRIEF.md
# Accumulator ALU with Flag Byte

This block is the arithmetic and logic unit of a 16-bit accumulator machine. Each cycle it is handed the accumulator value, one register operand and a five-bit operation code. It returns a combinational result word and a destination code. The destination code tells the surrounding datapath whether to write the result to the accumulator, to the selected register or to the compare register. The register file and the instruction sequencer sit outside this block and act on that code.

The block owns an 8-bit status byte. It holds carry, zero, overflow and negative flags at fixed bit positions. The byte is updated on a clock edge when the operation is marked valid, so branch logic downstream sees flags that reflect the last accepted operation. Each operation carries its own rule for carry and overflow: the flag is written, cleared or kept.

Top module: `alu16_top`

## Requirements
- R1: Operation codes are LOAD=0, STORE=1, ADD=2, SUB=3, CMP=4, MUL=5, DIV=6, AND=7, OR=8, XOR=9, NOT=10, SHL=11, SHR=12, ROL=13, ROR=14, INC=15, DEC=16. Codes 17 to 31 behave exactly as LOAD. LOAD returns the register operand and STORE returns the accumulator. Destination codes are 0 = accumulator, 1 = selected register, 2 = compare register.
- R2: The status byte holds carry in bit 0, zero in bit 1, overflow in bit 6 and negative in bit 7. Bits 2 to 5 always read 0. A synchronous reset clears the whole byte to 0x00.
- R3: ADD returns acc+reg and sets carry on a carry out of bit 15. SUB returns acc-reg and sets carry when a borrow occurs (acc < reg unsigned). Both set overflow on two's-complement signed overflow.
- R4: On every accepted operation, zero is set exactly when the 16-bit result is 0, and negative equals result bit 15.
- R5: SHL shifts the register operand left by one, fills bit 0 with 0 and puts the old bit 15 into carry. SHR shifts right by one, fills bit 15 with 0 and puts the old bit 0 into carry.
- R6: ROL and ROR rotate the full 16-bit register operand by one place, moving the departing bit into the opposite end. Both clear carry.
- R7: OR, XOR, NOT, INC, DEC, STORE, ROL and ROR clear carry. LOAD, MUL, DIV and AND keep carry unchanged.
- R8: CMP returns acc-reg with destination 2 and sets carry and overflow exactly as SUB does. It never targets the accumulator.
- R9: MUL returns the low 16 bits of the unsigned product. DIV returns the unsigned quotient acc/reg and clears overflow. A divisor of 0 makes DIV return 0xFFFF and set overflow.
- R10: Only ADD, SUB, CMP and DIV change the overflow flag. All other operations keep it.
- R11: The result and destination follow the inputs in the same cycle. The status byte changes only on a clock edge where op_valid_i is 1.
- R12: NOT, SHL, SHR, ROL, ROR, INC and DEC act on the register operand and return destination 1. AND, OR, XOR, ADD, SUB, MUL and DIV combine the accumulator with the register and return destination 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Commit the flag update for the current operation |
| op_i | input | 5 | Operation code |
| acc_i | input | 16 | Accumulator operand |
| reg_i | input | 16 | Selected register operand |
| result_o | output | 16 | Operation result |
| dest_o | output | 2 | Where the result is to be written |
| status_o | output | 8 | Status byte |

## Verification
The bench targets the edges of the carry and overflow rules:
- 0x7FF0+0x0010 should set overflow and negative. A design with the wrong overflow sign test would leave overflow clear.
- 0xFFFF+1 should set carry and zero. A design that dropped the seventeenth bit would lose the carry.
- A subtraction that borrows should set carry. A design with inverted borrow polarity would report the opposite.

It also checks that AND preserves a carry left by a prior shift; a design with a shared "logic clears carry" path would wipe it. Divide by zero must give all ones with overflow set, and a following valid divide must clear overflow. Four chained rotates of 0xAFDE must give 0xFDEA; a design that rotated only the low byte would give a different value. Held cycles with op_valid_i low must leave the flags frozen, and a compare must never target the accumulator.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [4:0] {
        OP_LOAD  = 5'd0,
        OP_STORE = 5'd1,
        OP_ADD   = 5'd2,
        OP_SUB   = 5'd3,
        OP_CMP   = 5'd4,
        OP_MUL   = 5'd5,
        OP_DIV   = 5'd6,
        OP_AND   = 5'd7,
        OP_OR    = 5'd8,
        OP_XOR   = 5'd9,
        OP_NOT   = 5'd10,
        OP_SHL   = 5'd11,
        OP_SHR   = 5'd12,
        OP_ROL   = 5'd13,
        OP_ROR   = 5'd14,
        OP_INC   = 5'd15,
        OP_DEC   = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        DST_ACC = 2'd0,
        DST_REG = 2'd1,
        DST_CMP = 2'd2
    } alu_dst_e;

    typedef enum logic [1:0] {
        CY_KEEP  = 2'd0,
        CY_CLEAR = 2'd1,
        CY_WRITE = 2'd2
    } cy_mode_e;

    typedef struct packed {
        alu_dst_e dst;
        cy_mode_e cy;
        logic     v_wr;
        logic     arith;
    } alu_ctrl_t;

    localparam int unsigned STAT_W = 8;
    localparam int unsigned ST_C   = 0;
    localparam int unsigned ST_Z   = 1;
    localparam int unsigned ST_V   = 6;
    localparam int unsigned ST_N   = 7;
    localparam int unsigned LAST_OP = 16;

    function automatic alu_op_e norm_op(logic [4:0] code);
        return (int'(code) > LAST_OP) ? OP_LOAD : alu_op_e'(code);
    endfunction

    function automatic alu_ctrl_t decode(alu_op_e op);
        alu_ctrl_t c;
        c.dst   = DST_ACC;
        c.cy    = CY_KEEP;
        c.v_wr  = 1'b0;
        c.arith = 1'b0;
        case (op)
            OP_STORE: begin c.dst = DST_REG; c.cy = CY_CLEAR; end
            OP_ADD, OP_SUB: begin c.cy = CY_WRITE; c.v_wr = 1'b1; c.arith = 1'b1; end
            OP_CMP: begin c.dst = DST_CMP; c.cy = CY_WRITE; c.v_wr = 1'b1; c.arith = 1'b1; end
            OP_MUL: c.arith = 1'b1;
            OP_DIV: begin c.v_wr = 1'b1; c.arith = 1'b1; end
            OP_OR, OP_XOR: c.cy = CY_CLEAR;
            OP_NOT, OP_ROL, OP_ROR: begin c.dst = DST_REG; c.cy = CY_CLEAR; end
            OP_SHL, OP_SHR: begin c.dst = DST_REG; c.cy = CY_WRITE; end
            OP_INC, OP_DEC: begin c.dst = DST_REG; c.cy = CY_CLEAR; c.arith = 1'b1; end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  alu_op_e        op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   res_o,
    output logic           cy_o,
    output logic           ov_o
);
    localparam int unsigned MSB = W - 1;

    logic [W:0]   sum_w;
    logic [W:0]   dif_w;
    logic [W-1:0] mul_w;
    logic [W-1:0] quo_w;
    logic         div0_w;

    assign sum_w  = {1'b0, a_i} + {1'b0, b_i};
    assign dif_w  = {1'b0, a_i} - {1'b0, b_i};
    assign mul_w  = a_i * b_i;
    assign div0_w = (b_i == '0);
    assign quo_w  = div0_w ? '1 : (a_i / b_i);

    always_comb begin
        res_o = b_i;
        cy_o  = 1'b0;
        ov_o  = 1'b0;
        case (op_i)
            OP_ADD: begin
                res_o = sum_w[W-1:0];
                cy_o  = sum_w[W];
                ov_o  = (a_i[MSB] == b_i[MSB]) && (sum_w[MSB] != a_i[MSB]);
            end
            OP_SUB, OP_CMP: begin
                res_o = dif_w[W-1:0];
                cy_o  = dif_w[W];
                ov_o  = (a_i[MSB] != b_i[MSB]) && (dif_w[MSB] != a_i[MSB]);
            end
            OP_MUL: res_o = mul_w;
            OP_DIV: begin
                res_o = quo_w;
                ov_o  = div0_w;
            end
            OP_INC: res_o = b_i + W'(1);
            OP_DEC: res_o = b_i - W'(1);
            default: ;
        endcase
    end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  alu_op_e        op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   res_o,
    output logic           cy_o
);
    always_comb begin
        res_o = b_i;
        cy_o  = 1'b0;
        case (op_i)
            OP_STORE: res_o = a_i;
            OP_AND:   res_o = a_i & b_i;
            OP_OR:    res_o = a_i | b_i;
            OP_XOR:   res_o = a_i ^ b_i;
            OP_NOT:   res_o = ~b_i;
            OP_SHL: begin
                res_o = {b_i[W-2:0], 1'b0};
                cy_o  = b_i[W-1];
            end
            OP_SHR: begin
                res_o = {1'b0, b_i[W-1:1]};
                cy_o  = b_i[0];
            end
            OP_ROL:   res_o = {b_i[W-2:0], b_i[W-1]};
            OP_ROR:   res_o = {b_i[0], b_i[W-1:1]};
            default: ;
        endcase
    end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
    import alu16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               upd_i,
    input  cy_mode_e           cy_mode_i,
    input  logic               v_wr_i,
    input  logic               cy_i,
    input  logic               ov_i,
    input  logic [W-1:0]       res_i,
    output logic [STAT_W-1:0]  stat_o
);
    logic [STAT_W-1:0] stat_q, stat_d;

    always_comb begin
        stat_d = stat_q;
        case (cy_mode_i)
            CY_CLEAR: stat_d[ST_C] = 1'b0;
            CY_WRITE: stat_d[ST_C] = cy_i;
            default: ;
        endcase
        if (v_wr_i) stat_d[ST_V] = ov_i;
        stat_d[ST_Z] = (res_i == '0);
        stat_d[ST_N] = res_i[W-1];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)      stat_q <= '0;
        else if (upd_i) stat_q <= stat_d;
    end

    assign stat_o = stat_q;

    // R2: reserved bits never set
    a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        stat_q[5:2] == 4'b0000);

    // R11: flags frozen without a valid operation
    a_r11_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !upd_i |=> $stable(stat_q));

    // R7: clearing operations leave carry at zero
    a_r7_carry_cleared: assert property (@(posedge clk_i) disable iff (rst_i)
        (upd_i && cy_mode_i == CY_CLEAR) |=> !stat_q[ST_C]);

    // R4: zero flag tracks the committed result
    a_r4_zero_flag: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_i |=> (stat_q[ST_Z] == ($past(res_i) == '0)));
endmodule

// File: rtl/alu16_top.sv
module alu16_top
    import alu16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               op_valid_i,
    input  logic [4:0]         op_i,
    input  logic [W-1:0]       acc_i,
    input  logic [W-1:0]       reg_i,
    output logic [W-1:0]       result_o,
    output logic [1:0]         dest_o,
    output logic [STAT_W-1:0]  status_o
);
    alu_op_e   op_w;
    alu_ctrl_t ctrl_w;
    logic [W-1:0] ar_res_w, lg_res_w, res_w;
    logic ar_cy_w, ar_ov_w, lg_cy_w;

    assign op_w   = norm_op(op_i);
    assign ctrl_w = decode(op_w);

    alu16_arith #(.W(W)) u_arith (
        .op_i (op_w),
        .a_i  (acc_i),
        .b_i  (reg_i),
        .res_o(ar_res_w),
        .cy_o (ar_cy_w),
        .ov_o (ar_ov_w)
    );

    alu16_logic #(.W(W)) u_logic (
        .op_i (op_w),
        .a_i  (acc_i),
        .b_i  (reg_i),
        .res_o(lg_res_w),
        .cy_o (lg_cy_w)
    );

    assign res_w = ctrl_w.arith ? ar_res_w : lg_res_w;

    alu16_flags #(.W(W)) u_flags (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .upd_i    (op_valid_i),
        .cy_mode_i(ctrl_w.cy),
        .v_wr_i   (ctrl_w.v_wr),
        .cy_i     (ctrl_w.arith ? ar_cy_w : lg_cy_w),
        .ov_i     (ar_ov_w),
        .res_i    (res_w),
        .stat_o   (status_o)
    );

    assign result_o = res_w;
    assign dest_o   = ctrl_w.dst;

    // R8: compare always targets the compare register with the difference
    a_r8_cmp_dest: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_w == OP_CMP) |-> (dest_o == DST_CMP && result_o == acc_i - reg_i));

    // R9: divide by zero yields all ones and raises overflow
    a_r9_div_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_valid_i && op_w == OP_DIV && reg_i == '0) |=>
            (status_o[ST_V] && $past(result_o) == '1));

    // R10: overflow kept by operations that do not define it
    a_r10_v_keep: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_valid_i && !(op_w inside {OP_ADD, OP_SUB, OP_CMP, OP_DIV}))
            |=> $stable(status_o[ST_V]));

    // R3: carry of an add equals the unsigned wrap
    a_r3_add_carry: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_valid_i && op_w == OP_ADD) |=>
            (status_o[ST_C] == ($past(result_o) < $past(acc_i))));
endmodule

// File: tb/alu16_tb.sv
module alu16_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        vld;
    logic [4:0]  op;
    logic [15:0] acc, rg;
    logic [15:0] res;
    logic [1:0]  dst;
    logic [7:0]  st;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [7:0] mstat;

    always #4 clk = ~clk;

    alu16_top dut_i (
        .clk_i(clk), .rst_i(rst), .op_valid_i(vld), .op_i(op),
        .acc_i(acc), .reg_i(rg), .result_o(res), .dest_o(dst), .status_o(st)
    );

    function automatic int eff(int o);
        return (o > 16) ? 0 : o;
    endfunction

    function automatic logic [15:0] f_res(int o, logic [15:0] a, logic [15:0] b);
        logic [31:0] p;
        p = 32'(a) * 32'(b);
        case (eff(o))
            1:  return a;
            2:  return a + b;
            3, 4: return a - b;
            5:  return p[15:0];
            6:  return (b == 0) ? 16'hFFFF : a / b;
            7:  return a & b;
            8:  return a | b;
            9:  return a ^ b;
            10: return ~b;
            11: return {b[14:0], 1'b0};
            12: return {1'b0, b[15:1]};
            13: return {b[14:0], b[15]};
            14: return {b[0], b[15:1]};
            15: return b + 16'd1;
            16: return b - 16'd1;
            default: return b;
        endcase
    endfunction

    function automatic logic [1:0] f_dst(int o);
        int e = eff(o);
        if (e == 4) return 2'd2;
        if (e == 1 || e >= 10) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [7:0] f_stat(int o, logic [15:0] a, logic [15:0] b, logic [7:0] old);
        logic c, v;
        logic [15:0] r;
        r = f_res(o, a, b);
        c = old[0];
        v = old[6];
        case (eff(o))
            2: begin
                c = (int'(a) + int'(b)) > 65535;
                v = (a[15] == b[15]) && (r[15] != a[15]);
            end
            3, 4: begin
                c = a < b;
                v = (a[15] != b[15]) && (r[15] != a[15]);
            end
            6:  v = (b == 0);
            11: c = b[15];
            12: c = b[0];
            1, 8, 9, 10, 13, 14, 15, 16: c = 1'b0;
            default: ;
        endcase
        return {r[15], v, 4'b0000, (r == 0), c};
    endfunction

    function automatic string tag_of(int o);
        case (eff(o))
            2, 3: return "R3";
            4: return "R8";
            5, 6: return "R9";
            11, 12: return "R5";
            13, 14: return "R6";
            10, 15, 16: return "R12";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic run_op(int o, logic [15:0] a, logic [15:0] b, bit v);
        @(negedge clk);
        op = 5'(o); acc = a; rg = b; vld = v;
        #1;
        check(tag_of(o), "result", res, f_res(o, a, b));
        check("R1", "dest", 16'(dst), 16'(f_dst(o)));
        @(posedge clk);
        #1;
        if (v) mstat = f_stat(o, a, b, mstat);
        check(v ? tag_of(o) : "R11", "status", 16'(st), 16'(mstat));
        check("R2", "reserved bits", 16'(st[5:2]), 16'h0);
        check("R4", "zero/neg", 16'({st[7], st[1]}), 16'({mstat[7], mstat[1]}));
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] x;
        void'($urandom(32'd1234));
        rst = 1'b1; vld = 1'b0; op = '0; acc = '0; rg = '0;
        mstat = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        check("R2", "reset status", 16'(st), 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        run_op(2, 16'h7FF0, 16'h0010, 1);    // R3 signed overflow to 0x8000
        check("R3", "V and N set", 16'(st), 16'h00C0);
        run_op(2, 16'hFFFF, 16'h0001, 1);    // R3 carry and zero
        check("R3", "C and Z set", 16'({st[0], st[1]}), 16'h3);
        run_op(3, 16'h0001, 16'h00FE, 1);    // R3 borrow
        check("R3", "borrow", 16'(st[0]), 16'h1);
        run_op(4, 16'h0A0D, 16'h0F0D, 1);    // R8 compare 0xFB00
        check("R8", "cmp value", res, 16'hFB00);
        run_op(11, 16'h0, 16'h8000, 1);      // R5 carry from SHL
        run_op(7, 16'h00FF, 16'h0F0F, 1);    // R7 AND keeps carry
        check("R7", "AND kept carry", 16'(st[0]), 16'h1);
        run_op(6, 16'h1234, 16'h0000, 1);    // R9 divide by zero
        check("R9", "div zero V", 16'(st[6]), 16'h1);
        run_op(5, 16'h0102, 16'h0201, 1);    // R9 multiply low half
        check("R10", "MUL kept V", 16'(st[6]), 16'h1);
        run_op(6, 16'h0007, 16'h0002, 1);    // R9 quotient 3, V cleared
        check("R9", "div quotient", res, 16'h0003);
        run_op(2, 16'h1111, 16'h2222, 0);    // R11 not committed
        run_op(20, 16'h5555, 16'hABCD, 1);   // R1 undefined code acts as load
        x = 16'hAFDE;
        for (int i = 0; i < 4; i++) begin    // R6 full-width rotate
            run_op(13, 16'h0, x, 1);
            x = f_res(13, 16'h0, x);
        end
        check("R6", "ROL x4", x, 16'hFDEA);
        run_op(14, 16'h0, 16'h0001, 1);      // R6 ROR wraps bit 0 into bit 15
        check("R6", "ROR wrap", res, 16'h8000);

        for (int i = 0; i < 3000; i++) begin
            int o;
            logic [15:0] a, b;
            o = int'($urandom_range(0, 16));
            a = 16'($urandom);
            b = 16'($urandom);
            if (($urandom & 7) == 0) b = 16'h0;
            run_op(o, a, b, ($urandom & 3) != 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule